// File: doc/BRIEF.md
# Serial Handshake Control Slave

This block is the slave end of a low-pin-count serial control link that an external master uses to read and write a chip's configuration registers. The master shares a serial clock and a serial command line among several slaves. Each slave has its own active-low select. All slaves share one serial response line. The slave's reset is active low and may be tied to the chip's global reset.

Once selected, the slave waits for a start bit. It then deserializes a header that holds a read/write flag, a command and an address. A write frame also carries a data word. The slave presents the transaction to the internal register logic with an exec strobe and holds it until that logic returns an ack, together with read data for a read. It then shifts a response frame out on the shared line.

The response output enable is raised only during the response phase while the slave is selected. Any number of slaves can therefore hang on one response wire, provided only one of them is selected at a time.

Top module: `sctl_slave`

## Requirements
- R1: After reset, `bus_exec` and `rsp_oe` are low.
- R2: While selected and idle, a 0 on `cmd_in` is ignored. A frame starts only when `cmd_in` is 1 at a clock edge with `sel_n` low.
- R3: After the start bit the header is received MSB first as {rw, cmd[CMD_W-1:0], addr[ADDR_W-1:0]}, where rw=1 means write. These fields appear on `bus_rw`, `bus_cmd` and `bus_addr` while `bus_exec` is high.
- R4: A write frame carries DATA_W more bits, MSB first, which appear on `bus_wdata`. A read frame carries no data bits, and exec follows the header directly.
- R5: `bus_exec` stays high, with stable fields, until a clock edge at which `bus_ack` is high. That edge captures `bus_rdata`.
- R6: After the ack, the response frame is a start bit of 1, then the header echoed MSB first, then DATA_W read-data bits MSB first for reads only. After the last bit the output enable falls.
- R7: `rsp_oe` is high only while the slave is selected and in its response phase, and never together with `bus_exec`.
- R8: Raising `sel_n` in any phase aborts the transaction. `rsp_oe` falls at once, `bus_exec` is low from the next edge, and the slave waits for a new start bit. An aborted write never reaches the register logic.
- R9: A slave whose `sel_n` is high ignores traffic on the shared command line: no exec, no response.
- R10: An ack that arrives while no exec is pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial link clock, all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low slave select |
| cmd_in | input | 1 | Serial command line from the master |
| rsp_out | output | 1 | Serial response bit (0 when not enabled) |
| rsp_oe | output | 1 | Output enable for the shared response line |
| bus_exec | output | 1 | Transaction request toward register logic |
| bus_rw | output | 1 | 1 = write, 0 = read |
| bus_cmd | output | CMD_W | Command field |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | DATA_W | Write data |
| bus_ack | input | 1 | Completion from register logic |
| bus_rdata | input | DATA_W | Read data, sampled with ack |

## Verification
The bench builds two slaves with CMD_W=3, ADDR_W=4 and DATA_W=8. Both sit on one command line and one resolved response wire, and each has a behavioural register file of 16 entries that acks after a latency depending on the address. At these widths every address of a slave can be written and read back in a full sweep. Every command value recurs, and each ack latency from zero to three cycles is exercised. Aborts in the header, data and response phases, stray acks and idle zeros are driven in between, and the untouched slave's exec count and contents are watched throughout.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_DATA,
        ST_EXEC,
        ST_RSP
    } sctl_state_e;
endpackage

// File: rtl/sctl_sipo.sv
module sctl_sipo #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] q
);
    logic [W-1:0] q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (en) begin
            q_d = {q_q[W-2:0], din};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign q = q_q;
endmodule

// File: rtl/sctl_piso.sv
module sctl_piso #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] pdin,
    output logic         sout
);
    logic [W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (load) begin
            sr_d = pdin;
        end else if (shift) begin
            sr_d = {sr_q[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign sout = sr_q[W-1];

    // R6
    load_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift));
endmodule

// File: rtl/sctl_slave.sv
module sctl_slave
    import sctl_pkg::*;
#(
    parameter int CMD_W  = 7,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              cmd_in,
    output logic              rsp_out,
    output logic              rsp_oe,
    output logic              bus_exec,
    output logic              bus_rw,
    output logic [CMD_W-1:0]  bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata
);
    localparam int HDR_W = 1 + CMD_W + ADDR_W;
    localparam int RSP_W = 1 + HDR_W + DATA_W;
    localparam int CNT_W = $clog2(RSP_W + 1);
    localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] WR_LAST   = CNT_W'(HDR_W);
    localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(HDR_W + DATA_W);

    typedef struct packed {
        sctl_state_e      state;
        logic [CNT_W-1:0] cnt;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic hdr_en, dat_en, rsp_ld, rsp_sh;
    logic [HDR_W-1:0]  hdr_q;
    logic [DATA_W-1:0] dat_q;
    logic [RSP_W-1:0]  rsp_word;
    logic              ser_bit;

    sctl_sipo #(.W(HDR_W)) hdr_sr_i (
        .clk(clk), .rst_n(rst_n), .en(hdr_en), .din(cmd_in), .q(hdr_q)
    );

    sctl_sipo #(.W(DATA_W)) dat_sr_i (
        .clk(clk), .rst_n(rst_n), .en(dat_en), .din(cmd_in), .q(dat_q)
    );

    assign rsp_word = {1'b1, hdr_q, (hdr_q[HDR_W-1] ? {DATA_W{1'b0}} : bus_rdata)};

    sctl_piso #(.W(RSP_W)) rsp_sr_i (
        .clk(clk), .rst_n(rst_n), .load(rsp_ld), .shift(rsp_sh),
        .pdin(rsp_word), .sout(ser_bit)
    );

    always_comb begin
        ctl_d  = ctl_q;
        hdr_en = 1'b0;
        dat_en = 1'b0;
        rsp_ld = 1'b0;
        rsp_sh = 1'b0;
        if (sel_n) begin
            ctl_d.state = ST_IDLE;
            ctl_d.cnt   = '0;
        end else begin
            unique case (ctl_q.state)
                ST_IDLE: begin
                    if (cmd_in) begin
                        ctl_d.state = ST_HDR;
                        ctl_d.cnt   = '0;
                    end
                end
                ST_HDR: begin
                    hdr_en    = 1'b1;
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                    if (ctl_q.cnt == HDR_LAST) begin
                        ctl_d.cnt   = '0;
                        // rw bit has already moved one place below the top
                        ctl_d.state = hdr_q[HDR_W-2] ? ST_DATA : ST_EXEC;
                    end
                end
                ST_DATA: begin
                    dat_en    = 1'b1;
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                    if (ctl_q.cnt == DATA_LAST) begin
                        ctl_d.cnt   = '0;
                        ctl_d.state = ST_EXEC;
                    end
                end
                ST_EXEC: begin
                    if (bus_ack) begin
                        rsp_ld      = 1'b1;
                        ctl_d.cnt   = '0;
                        ctl_d.state = ST_RSP;
                    end
                end
                ST_RSP: begin
                    rsp_sh    = 1'b1;
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                    if (ctl_q.cnt == (hdr_q[HDR_W-1] ? WR_LAST : RD_LAST)) begin
                        ctl_d.cnt   = '0;
                        ctl_d.state = ST_IDLE;
                    end
                end
                default: begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.cnt   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state <= ST_IDLE;
            ctl_q.cnt   <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign bus_exec  = (ctl_q.state == ST_EXEC);
    assign bus_rw    = hdr_q[HDR_W-1];
    assign bus_cmd   = hdr_q[HDR_W-2 -: CMD_W];
    assign bus_addr  = hdr_q[ADDR_W-1:0];
    assign bus_wdata = dat_q;
    assign rsp_oe    = (ctl_q.state == ST_RSP) && !sel_n;
    assign rsp_out   = rsp_oe & ser_bit;

    // R5
    exec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_exec && !bus_ack && !sel_n) |=> bus_exec);

    // R5
    exec_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_exec && $past(bus_exec)) |-> ($stable(bus_addr) && $stable(bus_cmd)
                                           && $stable(bus_rw) && $stable(bus_wdata)));

    // R8
    desel_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> (!bus_exec && !rsp_oe));

    // R7
    rsp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_oe |-> !bus_exec);
endmodule

// File: tb/sctl_slave_tb.sv
module sctl_slave_tb_top;
    localparam int CW = 3;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int HW = 1 + CW + AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd = 1'b0;
    logic sel_a = 1'b1;
    logic sel_b = 1'b1;
    logic ack_force = 1'b0;

    logic o_a, oe_a, ex_a, rw_a, ack_a, ackr_a;
    logic o_b, oe_b, ex_b, rw_b, ack_b, ackr_b;
    logic [CW-1:0] c_a, c_b;
    logic [AW-1:0] a_a, a_b;
    logic [DW-1:0] wd_a, wd_b, rd_a, rd_b;
    logic [DW-1:0] mem_a [16];
    logic [DW-1:0] mem_b [16];
    int lat_a, lat_b, nexec_a, nexec_b;
    int nerr = 0;
    int nchk = 0;
    int cycles = 0;

    logic busy, line;
    assign busy = oe_a | oe_b;
    assign line = oe_a ? o_a : (oe_b ? o_b : 1'b0);
    assign ack_a = ackr_a | ack_force;
    assign ack_b = ackr_b;

    always #5 clk = ~clk;

    sctl_slave #(.CMD_W(CW), .ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_a), .cmd_in(cmd),
        .rsp_out(o_a), .rsp_oe(oe_a), .bus_exec(ex_a), .bus_rw(rw_a),
        .bus_cmd(c_a), .bus_addr(a_a), .bus_wdata(wd_a),
        .bus_ack(ack_a), .bus_rdata(rd_a)
    );

    sctl_slave #(.CMD_W(CW), .ADDR_W(AW), .DATA_W(DW)) dut_b (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_b), .cmd_in(cmd),
        .rsp_out(o_b), .rsp_oe(oe_b), .bus_exec(ex_b), .bus_rw(rw_b),
        .bus_cmd(c_b), .bus_addr(a_b), .bus_wdata(wd_b),
        .bus_ack(ack_b), .bus_rdata(rd_b)
    );

    // register-file model behind slave A, latency = addr[1:0] cycles
    always @(negedge clk) begin
        if (!rst_n) begin
            ackr_a = 1'b0; lat_a = 0; nexec_a = 0; rd_a = '0;
            for (int i = 0; i < 16; i++) mem_a[i] = '0;
        end else if (ex_a && !ackr_a) begin
            if (lat_a >= int'(a_a[1:0])) begin
                if (rw_a) mem_a[a_a] = wd_a;
                rd_a = mem_a[a_a];
                ackr_a = 1'b1; lat_a = 0; nexec_a++;
            end else lat_a++;
        end else begin
            ackr_a = 1'b0; lat_a = 0;
        end
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            ackr_b = 1'b0; lat_b = 0; nexec_b = 0; rd_b = '0;
            for (int i = 0; i < 16; i++) mem_b[i] = '0;
        end else if (ex_b && !ackr_b) begin
            if (lat_b >= int'(a_b[1:0])) begin
                if (rw_b) mem_b[a_b] = wd_b;
                rd_b = mem_b[a_b];
                ackr_b = 1'b1; lat_b = 0; nexec_b++;
            end else lat_b++;
        end else begin
            ackr_b = 1'b0; lat_b = 0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic xfer(input bit to_b, input bit wr, input logic [CW-1:0] c,
                        input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        output logic [DW-1:0] rdo);
        logic [HW-1:0] hdr, echo;
        bit found;
        hdr = {wr, c, a};
        echo = '0; rdo = '0; found = 0;
        @(negedge clk);
        if (to_b) sel_b = 1'b0; else sel_a = 1'b0;
        cmd = 1'b0;
        @(negedge clk); cmd = 1'b1;
        for (int i = HW - 1; i >= 0; i--) begin @(negedge clk); cmd = hdr[i]; end
        if (wr) for (int i = DW - 1; i >= 0; i--) begin @(negedge clk); cmd = wd[i]; end
        @(negedge clk); cmd = 1'b0;
        for (int k = 0; k < 40; k++) begin
            if (busy) begin found = 1; break; end
            @(negedge clk);
        end
        chk("R6 start bit", {31'd0, found & line}, 32'd1);
        chk("R7 only selected drives", {31'd0, to_b ? oe_a : oe_b}, 32'd0);
        for (int i = HW - 1; i >= 0; i--) begin @(negedge clk); echo[i] = line; end
        chk("R3 R6 echo", 32'(echo), 32'(hdr));
        if (!wr) for (int i = DW - 1; i >= 0; i--) begin @(negedge clk); rdo[i] = line; end
        @(negedge clk);
        chk("R6 oe falls after last bit", {31'd0, busy}, 32'd0);
        sel_a = 1'b1; sel_b = 1'b1;
    endtask

    function automatic logic [DW-1:0] pat_a(input int a);
        return DW'(a * 37 + 11);
    endfunction
    function automatic logic [DW-1:0] pat_b(input int a);
        return DW'(8'hC3 ^ (a * 5));
    endfunction

    initial begin
        logic [DW-1:0] rd;
        int n0;
        repeat (3) @(negedge clk);
        chk("R1 oe_a", {31'd0, oe_a}, 0);
        chk("R1 exec_a", {31'd0, ex_a}, 0);
        chk("R1 oe_b", {31'd0, oe_b}, 0);
        chk("R1 exec_b", {31'd0, ex_b}, 0);
        rst_n = 1'b1;

        // R2: zeros while selected and idle start nothing
        @(negedge clk); sel_a = 1'b0; cmd = 1'b0;
        repeat (10) begin
            @(negedge clk);
            chk("R2 idle exec", {31'd0, ex_a}, 0);
        end
        chk("R2 idle no exec count", 32'(nexec_a), 0);
        sel_a = 1'b1;

        // R3 R4: write sweep on A, B must stay silent (R9)
        for (int a = 0; a < 16; a++) begin
            xfer(0, 1, CW'(a), AW'(a), pat_a(a), rd);
            chk("R4 write data delivered", 32'(mem_a[a]), 32'(pat_a(a)));
        end
        chk("R9 B no exec during A traffic", 32'(nexec_b), 0);

        for (int a = 0; a < 16; a++) begin
            xfer(0, 0, CW'(a + 3), AW'(a), '0, rd);
            chk("R6 read data", 32'(rd), 32'(pat_a(a)));
        end
        chk("R4 read frames carry no data", 32'(mem_a[5]), 32'(pat_a(5)));

        for (int a = 0; a < 16; a += 3) xfer(1, 1, CW'(a), AW'(a), pat_b(a), rd);
        for (int a = 0; a < 16; a += 3) begin
            xfer(1, 0, CW'(7), AW'(a), '0, rd);
            chk("R9 B readback", 32'(rd), 32'(pat_b(a)));
        end
        xfer(0, 0, '0, AW'(3), '0, rd);
        chk("R9 A untouched by B", 32'(rd), 32'(pat_a(3)));

        // R8: abort in header
        n0 = nexec_a;
        @(negedge clk); sel_a = 1'b0; @(negedge clk); cmd = 1'b1;
        repeat (3) begin @(negedge clk); cmd = ~cmd; end
        @(negedge clk); sel_a = 1'b1; cmd = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 header abort exec", {31'd0, ex_a}, 0);
        chk("R8 header abort oe", {31'd0, oe_a}, 0);

        // R8: abort in write data phase, value must not land
        @(negedge clk); sel_a = 1'b0; @(negedge clk); cmd = 1'b1;
        for (int i = HW - 1; i >= 0; i--) begin @(negedge clk); cmd = {1'b1, 3'd1, 4'd6} >> i; end
        repeat (4) begin @(negedge clk); cmd = 1'b1; end
        @(negedge clk); sel_a = 1'b1; cmd = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 aborts reach no exec", 32'(nexec_a), 32'(n0));
        xfer(0, 0, '0, AW'(6), '0, rd);
        chk("R8 aborted write not stored", 32'(rd), 32'(pat_a(6)));

        // R8: abort in response phase releases line at once
        @(negedge clk); sel_a = 1'b0; @(negedge clk); cmd = 1'b1;
        for (int i = HW - 1; i >= 0; i--) begin @(negedge clk); cmd = {1'b0, 3'd2, 4'd4} >> i; end
        @(negedge clk); cmd = 1'b0;
        for (int k = 0; k < 40 && !oe_a; k++) @(negedge clk);
        chk("R7 response phase oe", {31'd0, oe_a}, 1);
        @(negedge clk); @(negedge clk);
        sel_a = 1'b1; #1;
        chk("R8 oe released on deselect", {31'd0, oe_a}, 0);
        repeat (3) @(negedge clk);
        chk("R8 idle after abort", {31'd0, oe_a | ex_a}, 0);
        xfer(0, 0, '0, AW'(4), '0, rd);
        chk("R8 transaction after abort", 32'(rd), 32'(pat_a(4)));

        // R10: stray ack while idle, both deselected and selected
        n0 = nexec_a;
        @(negedge clk); ack_force = 1'b1;
        @(negedge clk); sel_a = 1'b0;
        @(negedge clk); ack_force = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk("R10 stray ack no response", {31'd0, oe_a}, 0);
        end
        sel_a = 1'b1;
        xfer(0, 0, '0, AW'(9), '0, rd);
        chk("R10 read after stray ack", 32'(rd), 32'(pat_a(9)));
        chk("R10 exec count", 32'(nexec_a), 32'(n0 + 1));

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            nerr++; nchk++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule